// File: doc/BRIEF.md
# Program Counter with Page Latch

This block holds the 13-bit instruction address of a small microcontroller core. The low eight bits form a byte that the core can read and overwrite with an ALU result. The upper five bits cannot be reached directly. They are filled from a separate five-bit page latch, which the core writes as an ordinary register. Two merge rules use this latch. A low-byte write copies all five latch bits into address bits 12:8. A jump or call puts the 11-bit opcode immediate in the lower bits and takes only latch bits 4:3 for address bits 12:11.

Returns load the full address from a value popped off an external stack. An interrupt request forces the fixed vector 0004h. In normal sequencing the whole 13-bit address advances by one and wraps at the top of the address space. A computed branch writes a new low byte and takes its page from the latch, so an offset added to the low byte never carries into the page bits.

Top module: `pc_unit`

## Requirements
- R1: While rst is high, pc_o is 0000h and the page latch is cleared, so a low-byte write that follows reset alone produces a page of 00000b.
- R2: With inc_en high and no other load requested, pc_o advances by one on the next edge, and 1FFFh is followed by 0000h.
- R3: When wr_lo is high, the next pc_o has bits 7:0 equal to alu_d and bits 12:8 equal to latch bits 4:0.
- R4: When jmp is high, the next pc_o has bits 10:0 equal to imm11 and bits 12:11 equal to latch bits 4:3.
- R5: When ret is high, the next pc_o equals stk_d.
- R6: When irq is high, the next pc_o equals 0004h.
- R7: When two or more loads are requested in the same cycle, the one that takes effect is chosen in this order, highest first: irq, ret, jmp, wr_lo, inc_en. When none is requested, pc_o holds its value.
- R8: When lat_we is high, the latch takes lat_d on the next edge. The latch changes at no other time. Returns and interrupts leave it unchanged.
- R9: pcl_o always equals pc_o bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inc_en | input | 1 | Advance the address by one |
| wr_lo | input | 1 | Write the low byte from alu_d |
| alu_d | input | 8 | ALU result for a low-byte write |
| jmp | input | 1 | Jump or call strobe |
| imm11 | input | 11 | Opcode immediate field |
| ret | input | 1 | Return strobe |
| stk_d | input | 13 | Return address popped from the stack |
| irq | input | 1 | Interrupt vector request |
| lat_we | input | 1 | Page latch write enable |
| lat_d | input | 5 | Page latch write data |
| pc_o | output | 13 | Full program address |
| pcl_o | output | 8 | Readable low byte |

## Verification
The assertions check every load rule on every cycle. These are the vector, the return load, both latch merge rules, the increment with wraparound, holding when no load is requested, and the low-byte mirror. The checker keeps its own copy of the latch, built only from lat_we and lat_d. The bench's directed scenarios are needed to show the rest. These are a computed branch at a page edge wrapping inside its page, the 1FFFh wrap, the latch staying unchanged through returns and interrupts, and the combinations of several strobes that show the priority order.

// File: rtl/pc_unit.sv
module pc_unit #(
  parameter int AW = 13,
  parameter int LW = 8,
  parameter int JW = 11,
  parameter logic [AW-1:0] VEC = 13'h0004
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_en,
  input  logic          wr_lo,
  input  logic [LW-1:0] alu_d,
  input  logic          jmp,
  input  logic [JW-1:0] imm11,
  input  logic          ret,
  input  logic [AW-1:0] stk_d,
  input  logic          irq,
  input  logic          lat_we,
  input  logic [AW-LW-1:0] lat_d,
  output logic [AW-1:0] pc_o,
  output logic [LW-1:0] pcl_o
);
  localparam int HW = AW - LW;
  localparam int JH = AW - JW;

  logic [AW-1:0] pc_q, pc_n;
  logic [HW-1:0] lat_q;

  wire [AW-1:0] jmp_addr = {lat_q[HW-1 -: JH], imm11};
  wire [AW-1:0] wr_addr  = {lat_q, alu_d};

  always_comb begin
    if (irq)         pc_n = VEC;
    else if (ret)    pc_n = stk_d;
    else if (jmp)    pc_n = jmp_addr;
    else if (wr_lo)  pc_n = wr_addr;
    else if (inc_en) pc_n = pc_q + 1'b1;
    else             pc_n = pc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      lat_q <= '0;
    end else begin
      pc_q <= pc_n;
      if (lat_we) lat_q <= lat_d;
    end
  end

  assign pc_o  = pc_q;
  assign pcl_o = pc_q[LW-1:0];
endmodule

module pc_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        inc_en,
  input logic        wr_lo,
  input logic [7:0]  alu_d,
  input logic        jmp,
  input logic [10:0] imm11,
  input logic        ret,
  input logic [12:0] stk_d,
  input logic        irq,
  input logic        lat_we,
  input logic [4:0]  lat_d,
  input logic [12:0] pc_o,
  input logic [7:0]  pcl_o
);
  logic [4:0] m_lat;
  always_ff @(posedge clk)
    if (rst) m_lat <= '0;
    else if (lat_we) m_lat <= lat_d;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> pc_o == 13'h0);
  // R6
  vector_chk: assert property (@(posedge clk) disable iff (rst) irq |=> pc_o == 13'h0004);
  // R5
  return_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ret && !irq) |=> pc_o == $past(stk_d));
  // R4
  jump_merge_chk: assert property (@(posedge clk) disable iff (rst)
    (jmp && !ret && !irq) |=> pc_o == {$past(m_lat[4:3]), $past(imm11)});
  // R3
  low_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !jmp && !ret && !irq) |=> pc_o == {$past(m_lat), $past(alu_d)});
  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_en && !wr_lo && !jmp && !ret && !irq) |=> pc_o == $past(pc_o) + 13'd1);
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!inc_en && !wr_lo && !jmp && !ret && !irq) |=> $stable(pc_o));
  // R9
  low_mirror_chk: assert property (@(posedge clk) pcl_o == pc_o[7:0]);
endmodule

bind pc_unit pc_unit_chk u_chk (.*);

// File: tb/sim_pc_unit.sv
module sim_pc_unit;
  logic clk = 0, rst = 1;
  logic inc_en = 0, wr_lo = 0, jmp = 0, ret = 0, irq = 0, lat_we = 0;
  logic [7:0] alu_d = 0;
  logic [10:0] imm11 = 0;
  logic [12:0] stk_d = 0;
  logic [4:0] lat_d = 0;
  logic [12:0] pc_o;
  logic [7:0] pcl_o;
  int n_chk = 0, n_bad = 0;
  int m_pc = 0, m_lat = 0;

  always #5 clk = ~clk;

  pc_unit u0 (.*);

  // reference model, updated from the inputs seen at each edge
  always @(posedge clk) begin
    if (rst) begin m_pc = 0; m_lat = 0; end
    else begin
      if (irq) m_pc = 4;
      else if (ret) m_pc = stk_d;
      else if (jmp) m_pc = (m_lat / 8) * 2048 + imm11;
      else if (wr_lo) m_pc = m_lat * 256 + alu_d;
      else if (inc_en) m_pc = (m_pc + 1) % 8192;
      if (lat_we) m_lat = lat_d;
    end
  end

  // every-clock comparison away from the edge
  always @(negedge clk) begin
    n_chk++;
    if (pc_o !== 13'(m_pc) || pcl_o !== 8'(m_pc % 256)) begin
      n_bad++;
      $display("FAIL R7/R9 cycle model: pc=%h pcl=%h expected %h", pc_o, pcl_o, 13'(m_pc));
    end
  end

  task automatic chk(input string r, input logic [12:0] exp);
    @(negedge clk); #1;
    n_chk++;
    if (pc_o !== exp) begin
      n_bad++;
      $display("FAIL %s: pc=%h expected %h", r, pc_o, exp);
    end
  endtask

  task automatic idle();
    {inc_en, wr_lo, jmp, ret, irq, lat_we} = '0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", 13'h0000);
    rst = 0;
    wr_lo = 1; alu_d = 8'h5A;                      chk("R1", 13'h005A); idle();
    lat_we = 1; lat_d = 5'h1D;                     chk("R8", 13'h005A); idle();
    wr_lo = 1; alu_d = 8'h34;                      chk("R3", 13'h1D34); idle();
    jmp = 1; imm11 = 11'h2AB;                      chk("R4", 13'h1AAB); idle();
    inc_en = 1;                                    chk("R2", 13'h1AAC);
    chk("R2", 13'h1AAD); idle();
    wr_lo = 1; alu_d = 8'hFF;                      chk("R3", 13'h1DFF); idle();
    wr_lo = 1; alu_d = 8'hFF + 8'h03;              chk("R3", 13'h1D02); idle();
    ret = 1; stk_d = 13'h1FFF;                     chk("R5", 13'h1FFF); idle();
    inc_en = 1;                                    chk("R2", 13'h0000); idle();
    irq = 1;                                       chk("R6", 13'h0004); idle();
    wr_lo = 1; alu_d = 8'h10;                      chk("R8", 13'h1D10); idle();
    irq = 1; ret = 1; jmp = 1; wr_lo = 1; inc_en = 1; stk_d = 13'h0777;
                                                   chk("R7", 13'h0004); idle();
    ret = 1; jmp = 1; wr_lo = 1; inc_en = 1;       chk("R7", 13'h0777); idle();
    jmp = 1; wr_lo = 1; inc_en = 1; imm11 = 11'h011; chk("R7", 13'h1811); idle();
    wr_lo = 1; inc_en = 1; alu_d = 8'h99;          chk("R7", 13'h1D99); idle();
    chk("R7", 13'h1D99);
    lat_we = 1; lat_d = 5'h06; jmp = 1; imm11 = 11'h7FF; chk("R8", 13'h1FFF); idle();
    jmp = 1; imm11 = 11'h000;                      chk("R4", 13'h0000); idle();
    rst = 1;                                       chk("R1", 13'h0000);
    rst = 0; wr_lo = 1; alu_d = 8'h01;             chk("R1", 13'h0001); idle();
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: pc=%h expected run end", pc_o);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule